// File: doc/BRIEF.md
# Quasi-Resonant Valley Pulse Generator

This block sits behind two comparators watching the auxiliary-winding sense node of a quasi-resonant switching controller. It turns their digitised outputs, together with the gate-drive signal, into a single-clock valley pulse. The switching logic uses that pulse to turn the power switch on again near a minimum of the switch-node ringing.

A pulse comes only from a complete and timely ring. While the gate is low, the sense node must first rise above the upper arming level. It must then fall through the lower detection level. That falling pass must come after a mask window timed from the gate's falling edge, and the pulse is issued a fixed delay after it. A falling pass without prior arming, or one inside the mask, uses up the arming and yields nothing. All activity while the gate is high is ignored. A rising gate also discards a pulse that is still waiting out its delay.

Both times are given in nanoseconds with the clock rate and are turned into cycle counts at elaboration. The defaults are a 100 MHz clock, a 500 ns delay (DELAY_CYC = 50) and a 2 us mask (MASK_CYC = 200).

Top module: `qr_valley_pulse`

## Requirements
- R1: While rst_n is low, and after its release until a qualified valley has been timed out, valley_o is 0.
- R2: Let T be the first clock edge that samples det_below_i at 1 after it was sampled at 0 (a falling crossing). If that crossing qualifies, valley_o is 1 for exactly one cycle, in the cycle after edge T + 2 + DELAY_CYC.
- R3: A falling crossing qualifies only if arm_above_i was sampled at 1, with gate_i low, at an edge no later than T - 1 since the previous crossing. Otherwise no pulse follows.
- R4: Every falling crossing clears the arming, whether or not it qualifies. A second crossing without a fresh arming sample yields no pulse.
- R5: Let G be the first edge that samples gate_i at 0. A crossing at T is masked, and yields no pulse, unless T >= G + MASK_CYC - 2.
- R6: While gate_i is sampled at 1, arming is cleared, no crossing qualifies and any pending pulse is dropped. A gate sampled high at the very edge where the pulse was due suppresses it.
- R7: An arming sample seen only while the gate is high does not arm the detector. Arming input that returns to 0 at least three edges before the gate falls leaves the detector unarmed.
- R8: A new qualified crossing while a pulse is pending restarts the delay. Only one pulse follows, timed from the newer crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_above_i | input | 1 | Comparator: sense node above the arming level (asynchronous) |
| det_below_i | input | 1 | Comparator: sense node below the detection level (asynchronous) |
| gate_i | input | 1 | Gate drive, 1 = switch on (synchronous) |
| valley_o | output | 1 | One-cycle valley pulse |

## Verification
The delicate coincidence is a pulse that falls due at the same clock edge as the gate's rising edge. The bench provokes it by raising the gate exactly DELAY_CYC + 2 cycles after the crossing, which must suppress the pulse. It then repeats the run with the gate raised one cycle later, which must let the pulse through. The mask boundary is treated the same way: the crossing is placed one cycle either side of the edge where the mask opens, and the cycle-accurate reference model together with explicit pulse counts judges each case.

// File: rtl/qrv_pkg.sv
package qrv_pkg;
   // Convert a time in ns to clock cycles at a clock of mhz, rounding up.
   function automatic int ns_to_cyc(input int mhz, input int ns);
      return (mhz * ns + 999) / 1000;
   endfunction

   function automatic int cnt_width(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction
endpackage

// File: rtl/qrv_sync.sv
module qrv_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qrv_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("qrv_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qrv_arm_detect.sv
module qrv_arm_detect #(
   parameter int MASK_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_s_i,
   input  logic det_s_i,
   input  logic gate_i,
   output logic qual_o
);
   localparam int MW = qrv_pkg::cnt_width(MASK_CYC);

   generate
      if (MASK_CYC < 1) begin : g_bad_mask
         $error("qrv_arm_detect: MASK_CYC must be at least 1");
      end
   endgenerate

   logic          det_q;
   logic          armed_q;
   logic [MW-1:0] mask_cnt_q;
   logic          cross_w;
   logic          mask_open_w;

   assign cross_w     = det_s_i & ~det_q;
   assign mask_open_w = (mask_cnt_q == '0);
   assign qual_o      = cross_w & armed_q & mask_open_w & ~gate_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_q      <= 1'b0;
         armed_q    <= 1'b0;
         mask_cnt_q <= MW'(MASK_CYC);
      end else begin
         det_q <= det_s_i;
         if (gate_i) begin
            armed_q    <= 1'b0;
            mask_cnt_q <= MW'(MASK_CYC);
         end else begin
            if (cross_w)      armed_q <= 1'b0;
            else if (arm_s_i) armed_q <= 1'b1;
            if (!mask_open_w) mask_cnt_q <= mask_cnt_q - MW'(1);
         end
      end
   end

   // R4
   disarm_after_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cross_w |=> !armed_q);

   // R5
   mask_on_gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_i) |-> !mask_open_w);
endmodule

// File: rtl/qrv_delay.sv
module qrv_delay #(
   parameter int DELAY_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic cancel_i,
   output logic valley_o
);
   localparam int DW = qrv_pkg::cnt_width(DELAY_CYC);

   generate
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("qrv_delay: DELAY_CYC must be at least 1");
      end
   endgenerate

   logic          pend_q;
   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         cnt_q    <= '0;
         valley_o <= 1'b0;
      end else if (cancel_i) begin
         pend_q   <= 1'b0;
         valley_o <= 1'b0;
      end else begin
         valley_o <= 1'b0;
         if (pend_q) begin
            if (cnt_q == DW'(1)) begin
               valley_o <= 1'b1;
               pend_q   <= 1'b0;
            end else begin
               cnt_q <= cnt_q - DW'(1);
            end
         end
         if (start_i) begin
            pend_q <= 1'b1;
            cnt_q  <= DW'(DELAY_CYC);
         end
      end
   end

   // R2
   valley_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valley_o |=> !valley_o);

   // R2
   valley_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valley_o) |-> $past(pend_q));

   // R6
   gate_blocks_valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_i |=> !valley_o);
endmodule

// File: rtl/qr_valley_pulse.sv
module qr_valley_pulse #(
   parameter int CLK_MHZ     = 100,
   parameter int DELAY_NS    = 500,
   parameter int MASK_NS     = 2000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_above_i,
   input  logic det_below_i,
   input  logic gate_i,
   output logic valley_o
);
   localparam int DELAY_CYC = qrv_pkg::ns_to_cyc(CLK_MHZ, DELAY_NS);
   localparam int MASK_CYC  = qrv_pkg::ns_to_cyc(CLK_MHZ, MASK_NS);

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("qr_valley_pulse: CLK_MHZ must be positive");
      end
   endgenerate

   logic [1:0] cmp_s;
   logic       qual_w;

   qrv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({arm_above_i, det_below_i}),
      .q_o   (cmp_s)
   );

   qrv_arm_detect #(.MASK_CYC(MASK_CYC)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_s_i (cmp_s[1]),
      .det_s_i (cmp_s[0]),
      .gate_i  (gate_i),
      .qual_o  (qual_w)
   );

   qrv_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (qual_w),
      .cancel_i (gate_i),
      .valley_o (valley_o)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !valley_o);
endmodule

// File: tb/qr_valley_pulse_test.sv
module qr_valley_pulse_test;
   localparam int CLK_PERIOD = 10;
   localparam int D = 50;
   localparam int M = 200;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0;
   logic det = 1'b0;
   logic gate = 1'b0;
   logic valley;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   int pulses = 0;
   int hi_cycles = 0;
   int last_pulse = -1;
   int t_gate = 0;
   int t_det = 0;
   string cur_req = "R1";
   logic prev_valley = 1'b0;
   bit done = 0;

   // reference model state
   bit ah[$];
   bit dh[$];
   bit m_armed;
   int m_mask;
   bit m_pend;
   int m_cnt;
   bit m_out;

   qr_valley_pulse uut (
      .clk(clk), .rst_n(rst_n), .arm_above_i(arm), .det_below_i(det),
      .gate_i(gate), .valley_o(valley)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         ah = '{0, 0};
         dh = '{0, 0, 0};
         m_armed = 0; m_mask = M; m_pend = 0; m_cnt = 0; m_out = 0;
      end else begin
         bit crossing;
         bit nout;
         crossing = dh[1] && !dh[2];
         nout = 0;
         if (gate) begin
            m_armed = 0; m_pend = 0; m_mask = M;
         end else begin
            if (m_pend) begin
               if (m_cnt == 1) begin nout = 1; m_pend = 0; end
               else m_cnt = m_cnt - 1;
            end
            if (crossing) begin
               if (m_armed && m_mask == 0) begin m_pend = 1; m_cnt = D; end
               m_armed = 0;
            end else if (ah[1]) begin
               m_armed = 1;
            end
            if (m_mask != 0) m_mask = m_mask - 1;
         end
         m_out = nout;
      end
      dh.push_front(det); void'(dh.pop_back());
      ah.push_front(arm); void'(ah.pop_back());
      if (cyc > WATCHDOG && !done) begin
         mismatched++;
         $display("FAIL %s watchdog: cycles %0d expected below %0d", cur_req, cyc, WATCHDOG);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         compared++;
         if (valley !== m_out) begin
            mismatched++;
            $display("FAIL %s cycle %0d: valley_o=%b expected %b", cur_req, cyc, valley, m_out);
         end
         if (valley === 1'b1) begin
            hi_cycles++;
            if (prev_valley !== 1'b1) begin pulses++; last_pulse = cyc; end
         end
         prev_valley = valley;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input bit g, input bit a, input bit d, input int n);
      gate = g; arm = a; det = d;
      if (g == 0 && gate_was_high) t_gate = cyc + 1;
      repeat (n) @(negedge clk);
   endtask

   bit gate_was_high;
   always @(negedge clk) gate_was_high = gate;

   // one switching cycle: gate on, then demagnetisation ring
   task automatic ring(input int det_at, input bit arm_en, input int tail);
      step(1, 0, 1, 20);
      step(0, 0, 0, 10);
      step(0, arm_en, 0, det_at - 11);
      step(0, 0, 0, 1);
      t_det = cyc + 1;
      step(0, 0, 1, tail);
   endtask

   task automatic clear_counts();
      pulses = 0; hi_cycles = 0; last_pulse = -1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(valley === 1'b0, "R1 valley_o during reset", int'(valley), 0);
      rst_n = 1'b1;
      step(0, 0, 0, 30);
      check(pulses == 0, "R1 no pulse after reset", pulses, 0);

      cur_req = "R2"; clear_counts();
      ring(250, 1, 80);
      check(pulses == 1, "R2 pulse count", pulses, 1);
      check(last_pulse == t_det + 2 + D, "R2 pulse timing", last_pulse, t_det + 2 + D);
      check(hi_cycles == 1, "R2 pulse width", hi_cycles, 1);

      cur_req = "R4"; clear_counts();
      step(0, 0, 0, 5);
      step(0, 0, 1, 80);
      check(pulses == 0, "R4 second crossing without arming", pulses, 0);

      cur_req = "R3"; clear_counts();
      ring(250, 0, 80);
      check(pulses == 0, "R3 crossing without arming", pulses, 0);

      cur_req = "R5"; clear_counts();
      ring(M - 2, 1, 80);
      check(pulses == 1, "R5 crossing at mask edge", pulses, 1);
      check(t_det - t_gate == M - 2, "R5 stimulus offset", t_det - t_gate, M - 2);
      clear_counts();
      ring(M - 3, 1, 80);
      check(pulses == 0, "R5 crossing inside mask", pulses, 0);

      cur_req = "R6"; clear_counts();
      for (int i = 0; i < 6; i++) begin
         step(1, 1, 0, 3);
         step(1, 0, 0, 2);
         step(1, 0, 1, 3);
      end
      step(1, 0, 1, 5);
      step(0, 0, 1, 300);
      check(pulses == 0, "R6 activity while gate high", pulses, 0);
      clear_counts();
      ring(250, 1, D + 2);
      step(1, 0, 1, 80);
      check(pulses == 0, "R6 gate rise at due edge", pulses, 0);
      clear_counts();
      ring(250, 1, D + 3);
      step(1, 0, 1, 80);
      check(pulses == 1, "R6 gate rise one edge after due", pulses, 1);
      clear_counts();
      ring(250, 1, 20);
      step(1, 0, 1, 80);
      check(pulses == 0, "R6 gate rise mid delay", pulses, 0);

      cur_req = "R7"; clear_counts();
      step(1, 1, 0, 10);
      step(1, 0, 0, 5);
      step(0, 0, 0, 249);
      step(0, 0, 1, 80);
      check(pulses == 0, "R7 arming only while gate high", pulses, 0);

      cur_req = "R8"; clear_counts();
      ring(250, 1, 5);
      step(0, 0, 0, 2);
      step(0, 1, 0, 3);
      step(0, 0, 0, 1);
      t_det = cyc + 1;
      step(0, 0, 1, 80);
      check(pulses == 1, "R8 restart pulse count", pulses, 1);
      check(last_pulse == t_det + 2 + D, "R8 restart timing", last_pulse, t_det + 2 + D);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule